// File: doc/BRIEF.md
# Flow-Through Burst SRAM with Sleep

This block is a synthesizable model of a synchronous SRAM with flow-through reads. It holds `DEPTH` words of 32 bits, split into four byte lanes. An access begins on a clock edge where either of two address strobes is low and all three chip selects are active. The processor strobe always starts a read. The controller strobe starts a read or a write, depending on the write enables. Later edges of the same access can hold the address, or step a 2-bit burst counter with the advance input. Each of those edges may be a read or a write. The higher address bits stay fixed for the whole burst.

Read data is flow-through. The addressed word appears combinationally after the edge that registers the address, with no pipeline stage. `rdata_vld` marks it valid, and `rdata` is forced to zero whenever the flag is low. The output enable works without the clock. It is masked during write cycles.

A level-sampled sleep request drives a four-state power machine:
- RUN → DOZE when the request is seen. This discards any open access.
- DOZE → SLEEP on the next edge.
- SLEEP → WAKE when the request is seen low.
- WAKE → RUN on the next edge.

Accesses are accepted only in RUN while no request is present. A second machine tracks the access:
- IDLE → RD or IDLE → WR on a selected strobe.
- RD or WR → RD or WR on each continuation edge.
- Any state → IDLE on a deselect strobe or while not accepting.

Top module: `sram_flow_burst`

## Requirements
- R1: With `order_ilv`=1, the low two address bits on burst step k (k=0..3) are the start bits XOR k. For example, a start of 01 visits 01, 00, 11, 10.
- R2: With `order_ilv`=0, the low two bits on step k are the start bits plus k, modulo 4. For example, a start of 10 visits 10, 11, 00, 01. After the fourth address, the next advance returns to the start.
- R3: On an edge with no strobe during an open access, `burst_adv_n`=0 moves the burst one step and `burst_adv_n`=1 holds the address. Address bits above bit 1 never change within a burst.
- R4: An access started by `cpu_strb_n`=0 is a read on that edge, whatever the write enables are. Nothing is written.
- R5: An access started by `ctl_strb_n`=0 alone with a write request writes `wdata` to `addr` on that edge. A continuation edge with a write request writes to the current address, or to the advanced address if it also advances.
- R6: A write request exists when `wr_all_n`=0, or when `wr_byte_n`=0 and some `lane_we_n` bit is 0. `wr_all_n`=0 writes all four lanes. Otherwise lane i (bits 8i+7:8i) is written when `lane_we_n[i]`=0. With every lane enable high, the edge is a read.
- R7: After a read edge, `rdata` shows the word at the registered address in the same cycle, and `rdata_vld`=1 while `out_en_n`=0.
- R8: `rdata_vld` follows `out_en_n` without a clock. It is 0, with `rdata`=0, when `out_en_n`=1, after a write edge, or when no access is open.
- R9: A strobe edge where the selects are not `cs0_n`=0, `cs1`=1 and `cs2_n`=0 closes any access. Data stays invalid until the next access.
- R10: If `sleep_req`=1 is seen in RUN, the open access is discarded on that edge, and SLEEP is reached on the following edge. No access is accepted from the first of those edges.
- R11: When `sleep_req`=0 is seen in SLEEP, a strobe on the next edge is ignored. A strobe on the edge after that is accepted. Memory contents survive sleep.
- R12: `rst_n`=0 asynchronously puts both machines in RUN and IDLE, with `rdata_vld`=0 and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| cpu_strb_n | input | 1 | Processor address strobe, active low, read-only start |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write enable, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Sleep request |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when not valid |
| rdata_vld | output | 1 | Read data valid |

## Verification
The bench builds the block with `DEPTH`=32, so the address is 5 bits and only 8 burst groups exist. Random bursts therefore revisit, and partly overwrite, words written earlier, which exercises byte-lane merging against stale data. At this depth, filling the whole array and re-reading it after sleep takes only a few dozen cycles.

// File: rtl/sram_fb_pkg.sv
package sram_fb_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;
    localparam int CTR_W  = 2;

    typedef enum logic [1:0] {
        PWR_RUN,
        PWR_DOZE,
        PWR_SLEEP,
        PWR_WAKE
    } pwr_st_t;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_RD,
        ACC_WR
    } acc_st_t;
endpackage

// File: rtl/sram_fb_pwr.sv
module sram_fb_pwr
    import sram_fb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sleep_req,
    output pwr_st_t pwr,
    output logic    awake
);
    pwr_st_t pwr_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwr <= PWR_RUN;
        else        pwr <= pwr_nxt;
    end

    always_comb begin
        pwr_nxt = pwr;
        unique case (pwr)
            PWR_RUN:   if (sleep_req)  pwr_nxt = PWR_DOZE;
            PWR_DOZE:  pwr_nxt = PWR_SLEEP;
            PWR_SLEEP: if (!sleep_req) pwr_nxt = PWR_WAKE;
            PWR_WAKE:  pwr_nxt = PWR_RUN;
            default:   pwr_nxt = PWR_RUN;
        endcase
    end

    always_comb begin
        awake = (pwr == PWR_RUN);
    end
endmodule

// File: rtl/sram_fb_ctr.sv
module sram_fb_ctr
    import sram_fb_pkg::*;
(
    input  logic [CTR_W-1:0] start_lo,
    input  logic [CTR_W-1:0] step,
    input  logic             order_ilv,
    output logic [CTR_W-1:0] nxt_lo
);
    logic [CTR_W-1:0] step_inc;

    always_comb begin
        step_inc = step + CTR_W'(1);
        nxt_lo   = order_ilv ? (start_lo ^ step_inc) : (start_lo + step_inc);
    end
endmodule

// File: rtl/sram_fb_store.sv
module sram_fb_store
    import sram_fb_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  lane_en,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] arr [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[g]) arr[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = arr[raddr];
    end
endmodule

// File: rtl/sram_flow_burst.sv
module sram_flow_burst
    import sram_fb_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int HI_W = AW - CTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              cpu_strb_n,
    input  logic              ctl_strb_n,
    input  logic              burst_adv_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              cs0_n,
    input  logic              cs1,
    input  logic              cs2_n,
    input  logic              out_en_n,
    input  logic              sleep_req,
    input  logic              order_ilv,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_vld
);
    pwr_st_t          pwr;
    logic             awake;
    acc_st_t          acc_st, acc_nxt;
    logic [HI_W-1:0]  cur_hi;
    logic [CTR_W-1:0] cur_lo, start_lo, step, nxt_lo, tgt_lo;
    logic             sel, cpu_go, strobe, accept, start_ok, cont, adv;
    logic             wr_req, wr_go;
    logic [LANES-1:0] lane_en;
    logic [AW-1:0]    waddr;
    logic [WORD_W-1:0] mem_word;

    sram_fb_pwr u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .pwr       (pwr),
        .awake     (awake)
    );

    sram_fb_ctr u_ctr (
        .start_lo  (start_lo),
        .step      (step),
        .order_ilv (order_ilv),
        .nxt_lo    (nxt_lo)
    );

    sram_fb_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .we      (wr_go),
        .lane_en (lane_en),
        .waddr   (waddr),
        .wdata   (wdata),
        .raddr   ({cur_hi, cur_lo}),
        .rdata   (mem_word)
    );

    // Edge qualification and write decode
    always_comb begin
        sel      = !cs0_n && cs1 && !cs2_n;
        cpu_go   = !cpu_strb_n;
        strobe   = cpu_go || !ctl_strb_n;
        accept   = awake && !sleep_req;
        start_ok = accept && strobe && sel;
        cont     = accept && !strobe && (acc_st != ACC_IDLE);
        adv      = cont && !burst_adv_n;
        tgt_lo   = adv ? nxt_lo : cur_lo;
        wr_req   = !wr_all_n || (!wr_byte_n && !(&lane_we_n));
        lane_en  = !wr_all_n ? {LANES{1'b1}} : (!wr_byte_n ? ~lane_we_n : '0);
        wr_go    = ((start_ok && !cpu_go) || cont) && wr_req;
        waddr    = start_ok ? addr : {cur_hi, tgt_lo};
    end

    // Access state: next state
    always_comb begin
        acc_nxt = acc_st;
        if (!accept) begin
            acc_nxt = ACC_IDLE;
        end else if (start_ok) begin
            acc_nxt = wr_go ? ACC_WR : ACC_RD;
        end else if (strobe) begin
            acc_nxt = ACC_IDLE;
        end else begin
            unique case (acc_st)
                ACC_IDLE: acc_nxt = ACC_IDLE;
                ACC_RD,
                ACC_WR:   acc_nxt = wr_go ? ACC_WR : ACC_RD;
                default:  acc_nxt = ACC_IDLE;
            endcase
        end
    end

    // Access state register and burst address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_st   <= ACC_IDLE;
            cur_hi   <= '0;
            cur_lo   <= '0;
            start_lo <= '0;
            step     <= '0;
        end else begin
            acc_st <= acc_nxt;
            if (start_ok) begin
                cur_hi   <= addr[AW-1:CTR_W];
                cur_lo   <= addr[CTR_W-1:0];
                start_lo <= addr[CTR_W-1:0];
                step     <= '0;
            end else if (adv) begin
                cur_lo <= nxt_lo;
                step   <= step + CTR_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        rdata_vld = 1'b0;
        unique case (acc_st)
            ACC_IDLE: rdata_vld = 1'b0;
            ACC_RD:   rdata_vld = !out_en_n;
            ACC_WR:   rdata_vld = 1'b0;
            default:  rdata_vld = 1'b0;
        endcase
        rdata = rdata_vld ? mem_word : '0;
    end
endmodule

// File: rtl/sram_flow_burst_chk.sv
module sram_flow_burst_chk
    import sram_fb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_req,
    input logic              out_en_n,
    input logic [WORD_W-1:0] rdata,
    input logic              rdata_vld,
    input pwr_st_t           pwr,
    input acc_st_t           acc_st,
    input logic              accept,
    input logic              start_ok,
    input logic              cpu_go,
    input logic              strobe,
    input logic              sel
);
    // R8
    oe_gates_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_vld |-> !out_en_n);

    // R8
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_vld |-> (rdata == '0));

    // R4
    cpu_start_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && cpu_go) |=> (acc_st == ACC_RD));

    // R9
    deselect_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && strobe && !sel) |=> (acc_st == ACC_IDLE));

    // R10
    doze_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr == PWR_RUN && sleep_req) |=> (pwr == PWR_DOZE && acc_st == ACC_IDLE));

    // R10
    doze_to_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr == PWR_DOZE) |=> (pwr == PWR_SLEEP));

    // R11
    wake_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr == PWR_WAKE) |=> (pwr == PWR_RUN));

    // R10
    idle_off_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr != PWR_RUN) |-> (acc_st == ACC_IDLE));
endmodule

bind sram_flow_burst sram_flow_burst_chk u_chk (.*);

// File: tb/test_sram_flow_burst.sv
module test_sram_flow_burst;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;
    localparam int AW         = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          cpu_strb_n, ctl_strb_n, burst_adv_n, wr_all_n, wr_byte_n;
    logic [3:0]    lane_we_n;
    logic          cs0_n, cs1, cs2_n, out_en_n, sleep_req, order_ilv;
    logic [31:0]   wdata, rdata;
    logic          rdata_vld;

    sram_flow_burst #(.DEPTH(DEPTH)) i_sram_flow_burst (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_strb_n(cpu_strb_n),
        .ctl_strb_n(ctl_strb_n), .burst_adv_n(burst_adv_n), .wr_all_n(wr_all_n),
        .wr_byte_n(wr_byte_n), .lane_we_n(lane_we_n), .cs0_n(cs0_n), .cs1(cs1),
        .cs2_n(cs2_n), .out_en_n(out_en_n), .sleep_req(sleep_req),
        .order_ilv(order_ilv), .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0]   model [DEPTH];
    int            tests = 0;
    int            fails = 0;
    logic [AW-3:0] b_hi;
    logic [1:0]    b_start, b_k;
    logic          b_ilv;

    function automatic logic [1:0] exp_lo(logic [1:0] s, logic [1:0] k, logic ilv);
        return ilv ? (s ^ k) : (s + k);
    endfunction

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] ln);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++) if (ln[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic defaults();
        cpu_strb_n = 1; ctl_strb_n = 1; burst_adv_n = 1; wr_all_n = 1; wr_byte_n = 1;
        lane_we_n = 4'hF; cs0_n = 0; cs1 = 1; cs2_n = 0; out_en_n = 0; wdata = '0;
        order_ilv = b_ilv;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_start(input logic [AW-1:0] a, input logic [31:0] d);
        defaults(); ctl_strb_n = 0; wr_all_n = 0; addr = a; wdata = d;
        tick();
        model[a] = d;
        b_hi = a[AW-1:2]; b_start = a[1:0]; b_k = 0;
        chk("R5 write-start valid", {31'd0, rdata_vld}, 32'd0);
    endtask

    task automatic read_start(input logic [AW-1:0] a, input bit use_cpu, input logic ilv);
        b_ilv = ilv;
        defaults(); addr = a;
        if (use_cpu) cpu_strb_n = 0; else ctl_strb_n = 0;
        tick();
        b_hi = a[AW-1:2]; b_start = a[1:0]; b_k = 0;
        chk("R7 read-start valid", {31'd0, rdata_vld}, 32'd1);
        chk("R7 read-start data", rdata, model[a]);
    endtask

    task automatic burst_step(input bit adv, input bit do_wr, input bit gw,
                              input logic [3:0] ln, input logic [31:0] d, input bit oe_off);
        logic [AW-1:0] a;
        bit eff;
        defaults(); burst_adv_n = !adv; wdata = d;
        if (do_wr) begin
            if (gw) wr_all_n = 0;
            else begin wr_byte_n = 0; lane_we_n = ~ln; end
        end
        out_en_n = oe_off;
        tick();
        if (adv) b_k = b_k + 2'd1;
        a = {b_hi, exp_lo(b_start, b_k, b_ilv)};
        eff = do_wr && (gw || ln != 4'h0);
        if (eff) model[a] = merge(model[a], d, gw ? 4'hF : ln);
        if (eff || oe_off) begin
            chk("R8 valid low on write/oe off", {31'd0, rdata_vld}, 32'd0);
            chk("R8 data zero", rdata, 32'd0);
        end else begin
            chk("R3 burst step valid (R1/R2 order, R6 no-lane read)", {31'd0, rdata_vld}, 32'd1);
            chk("R3 burst step data", rdata, model[a]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        b_ilv = 0; addr = '0; sleep_req = 0;
        defaults();
        rst_n = 0;
        repeat (3) tick();
        // R12 reset state
        chk("R12 valid after reset", {31'd0, rdata_vld}, 32'd0);
        chk("R12 data after reset", rdata, 32'd0);
        rst_n = 1;
        tick();

        for (int i = 0; i < DEPTH; i++) write_start(AW'(i), $urandom);

        // R1 interleaved from 01, full loop plus wrap
        read_start(AW'(5'b01001), 0, 1);
        for (int s = 0; s < 4; s++) burst_step(1, 0, 0, 4'h0, 0, 0);
        chk("R1 wrap back to start", rdata, model[5'b01001]);
        // R2 linear from 10
        read_start(AW'(5'b10110), 1, 0);
        for (int s = 0; s < 4; s++) burst_step(1, 0, 0, 4'h0, 0, 0);
        chk("R2 wrap back to start", rdata, model[5'b10110]);
        // R3 hold
        burst_step(0, 0, 0, 4'h0, 0, 0);
        burst_step(0, 0, 0, 4'h0, 0, 0);

        // R4 processor strobe ignores write enables
        defaults(); cpu_strb_n = 0; wr_all_n = 0; addr = 5'd3; wdata = 32'hDEAD_BEEF;
        tick();
        chk("R4 cpu start is read", {31'd0, rdata_vld}, 32'd1);
        chk("R4 old data shown", rdata, model[3]);
        read_start(5'd3, 0, 0);
        chk("R4 word unchanged", rdata, model[3]);

        // R5 controller write then continuation byte write (R6)
        write_start(5'd12, 32'h1122_3344);
        burst_step(0, 1, 0, 4'b0101, 32'hAABB_CCDD, 0);
        read_start(5'd12, 0, 0);
        chk("R6 lane merge", rdata, 32'h11BB_33DD);
        chk("R5 model agrees", rdata, model[12]);

        // R8 asynchronous output enable
        #1 out_en_n = 1;
        #1 chk("R8 oe off mid-cycle", {31'd0, rdata_vld}, 32'd0);
        out_en_n = 0;
        #1 chk("R8 oe back on", rdata, model[12]);
        @(negedge clk);

        // R9 deselect
        defaults(); ctl_strb_n = 0; cs1 = 0; addr = 5'd1;
        tick();
        chk("R9 deselect invalidates", {31'd0, rdata_vld}, 32'd0);
        defaults();
        tick();
        chk("R9 stays closed", {31'd0, rdata_vld}, 32'd0);

        // R10 sleep entry discards pending read
        read_start(5'd20, 1, 1);
        defaults(); sleep_req = 1;
        tick();
        chk("R10 pending access dropped", {31'd0, rdata_vld}, 32'd0);
        repeat (4) tick();
        // R11 wake: strobe on first edge ignored, second accepted
        sleep_req = 0;
        tick();
        defaults(); cpu_strb_n = 0; addr = 5'd20;
        tick();
        chk("R11 strobe in wake ignored", {31'd0, rdata_vld}, 32'd0);
        tick();
        chk("R11 accepted after wake", {31'd0, rdata_vld}, 32'd1);
        chk("R11 contents kept", rdata, model[20]);
        for (int i = 0; i < DEPTH; i += 7) read_start(AW'(i), 0, 0);

        // Random bursts
        for (int n = 0; n < 300; n++) begin
            int steps;
            logic [AW-1:0] a = AW'($urandom_range(0, DEPTH-1));
            if ($urandom_range(0, 3) == 0) write_start(a, $urandom);
            else read_start(a, 1'($urandom), 1'($urandom));
            if ($urandom_range(0, 1) == 1) b_ilv = 1'($urandom);
            steps = $urandom_range(3, 6);
            for (int s = 0; s < steps; s++)
                burst_step(1'($urandom), $urandom_range(0, 3) == 0, 1'($urandom),
                           4'($urandom), $urandom, $urandom_range(0, 7) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule